// File: doc/BRIEF.md
# Low-Power Stop Sequencer

This block decides when a microcontroller may shut down its main oscillator and when the CPU may run again. The CPU raises a stop request. If the CPU is running from the main clock, the sequencer accepts the request. It then either turns the main oscillator off or, when an enabled interrupt is already waiting, drops straight into a halt-like hold. In both cases it holds the CPU off until the oscillator has had time to settle. That settling time is set by a 3-bit select code.

While the main oscillator is off, the block gates each peripheral. The choice depends on whether that peripheral's chosen clock still runs in this state, which means the subsystem clock or an external count input. It also drives the clock-output and buzzer pins low where required. A hold signal tells the output ports to keep their latched values. A one-cycle acknowledge marks entry into the stopped state, and a one-cycle completion pulse marks the return to run. The controller runs on an always-on clock. Interrupt lines can pass through a synchronizer of configurable depth (`SYNC_STAGES`). The timings below assume `SYNC_STAGES` = 0, and each extra stage delays every reaction to an interrupt by one cycle.

Top module: `stby_stop_ctrl`

## Requirements
- R1: After reset the controller is in run: `cpu_run`=1, `main_osc_en`=1, `stop_ack`=0, `wake_done`=0, `port_hold`=0.
- R2: A `stop_req` while `cpu_on_sub`=1 is ignored: `cpu_run` and `main_osc_en` stay 1 and `stop_ack` stays 0.
- R3: An accepted request with no pending interrupt gives, one cycle later, `main_osc_en`=0, `cpu_run`=0 and `stop_ack`=1. `stop_ack` lasts exactly one cycle.
- R4: If some bit has `irq_req`=1 and `irq_mask`=0 when a request is accepted, the controller enters a hold instead. `main_osc_en` stays 1, `cpu_run`=0 and `stop_ack` pulses. One cycle later the stabilization wait starts.
- R5: In the stopped state, an interrupt with `irq_mask`=1 has no effect. An interrupt with `irq_mask`=0 sets `main_osc_en`=1 on the next cycle.
- R6: `cpu_run` rises exactly 2^E cycles after the cycle in which `main_osc_en` rose. On the hold path it rises 1+2^E cycles after the hold begins.
- R7: `stab_sel` selects E as follows: code 0 gives EXP0, 1 gives EXP1, 2 gives EXP2, 3 gives EXP3, and 4 gives EXP4. Codes 5, 6 and 7 give EXP4, the longest wait. The defaults are 12, 14, 15, 16 and 17.
- R8: `wake_done` is high for exactly the first cycle in which `cpu_run` is 1 again.
- R9: `port_hold` is 1 in every cycle in which the controller is not in run.
- R10: While the oscillator is off, `tmr16_en`=0, `wdt_en`=0 and `buz_force_low`=1. In all other states every enable is 1 and both force outputs are 0.
- R11: While the oscillator is off, `wt_en` = `wt_src_sub` AND `sub_clk_present`.
- R12: While the oscillator is off, `clkout_force_low` = NOT(`clkout_src_sub` AND `sub_clk_present`).
- R13: While the oscillator is off, `tmr8_en` = `tmr8_src_ext`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_req | input | 1 | Stop request from the CPU |
| cpu_on_sub | input | 1 | 1 = CPU currently clocked from the subsystem clock |
| sub_clk_present | input | 1 | 1 = subsystem oscillator running |
| irq_req | input | N_IRQ | Interrupt request flags |
| irq_mask | input | N_IRQ | Interrupt mask flags, 1 = masked |
| stab_sel | input | 3 | Stabilization-time select code |
| wt_src_sub | input | 1 | Watch timer counts the subsystem clock |
| clkout_src_sub | input | 1 | Clock-output pin sources the subsystem clock |
| tmr8_src_ext | input | 1 | 8-bit timer counts an external input |
| main_osc_en | output | 1 | Main oscillator enable |
| cpu_run | output | 1 | CPU run enable |
| stop_ack | output | 1 | One-cycle pulse on stop entry |
| wake_done | output | 1 | One-cycle pulse on return to run |
| port_hold | output | 1 | Output latches hold their values |
| tmr16_en | output | 1 | 16-bit timer enable |
| wdt_en | output | 1 | Watchdog enable |
| wt_en | output | 1 | Watch timer enable |
| tmr8_en | output | 1 | 8-bit timer enable |
| clkout_force_low | output | 1 | Force clock-output pin low |
| buz_force_low | output | 1 | Force buzzer pin low |

## Verification
The case that is hardest to reach from the ports is an enabled interrupt that is already pending at the moment a stop is accepted. Reaching it needs the request flag raised and unmasked in the same cycle as the stop request. The bench drives both on one falling edge. It then checks that the oscillator never turns off and that the wait runs one cycle longer than on the normal path. A masked interrupt held through a long stopped interval is the second corner case. The bench also walks all 16 combinations of the subsystem-clock and source-select inputs, and builds each combination inside its own stop cycle.

// File: rtl/stby_pkg.sv
// Shared types and helpers for the stop sequencer.
// Assumes the caller passes exponents with the longest one last.
package stby_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STOP = 2'd1,
        ST_WAIT = 2'd2,
        ST_HALT = 2'd3
    } stby_state_t;

    // Map a select code to a wait exponent; codes above 4 take the longest.
    function automatic int unsigned pick_exp(input logic [2:0] code,
                                             input int unsigned e0,
                                             input int unsigned e1,
                                             input int unsigned e2,
                                             input int unsigned e3,
                                             input int unsigned e4);
        case (code)
            3'd0:    return e0;
            3'd1:    return e1;
            3'd2:    return e2;
            3'd3:    return e3;
            default: return e4;
        endcase
    endfunction

endpackage

// File: rtl/stby_wake_detect.sv
// Reduces request and mask flags to one "wake pending" level.
// With SYNC_STAGES > 0 each unmasked line passes a flop chain first,
// since interrupt sources may be asynchronous to the controller clock.
module stby_wake_detect #(
    parameter int N_IRQ       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_mask,
    output logic             wake_pend
);

    logic [N_IRQ-1:0] live;
    assign live = irq_req & ~irq_mask;

    generate
        if (SYNC_STAGES == 0) begin : g_direct
            assign wake_pend = |live;
        end else begin : g_sync
            logic [N_IRQ-1:0] chain [SYNC_STAGES];
            // Shift the unmasked flags through the synchronizer.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= '0;
                end else begin
                    chain[0] <= live;
                    for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
                end
            end
            assign wake_pend = |chain[SYNC_STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/stby_stab_timer.sv
// Oscillation-stabilization down-counter. A start pulse loads 2^E-1,
// where E comes from the select code. While enabled it counts to zero.
// Assumes EXP4 is the largest exponent; it sets the counter width.
module stby_stab_timer
    import stby_pkg::*;
#(
    parameter int unsigned EXP0 = 12,
    parameter int unsigned EXP1 = 14,
    parameter int unsigned EXP2 = 15,
    parameter int unsigned EXP3 = 16,
    parameter int unsigned EXP4 = 17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       en,
    input  logic [2:0] sel,
    output logic       expired
);

    localparam int CW = EXP4;

    logic [CW-1:0] cnt;
    logic [CW-1:0] load_val;
    int unsigned   exp_sel;

    // Derive the load value from the selected exponent.
    always_comb begin
        exp_sel  = pick_exp(sel, EXP0, EXP1, EXP2, EXP3, EXP4);
        load_val = CW'((64'd1 << exp_sel) - 64'd1);
    end

    // Load on start, otherwise step toward zero while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (start)            cnt <= load_val;
        else if (en && cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    assert_count_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && en && !expired) |=> (cnt == $past(cnt) - 1'b1));

    assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !expired || $past(load_val) == '0);

endmodule

// File: rtl/stby_periph_gate.sv
// Peripheral enables and pin forcing while the main oscillator is off.
// Outside that state everything is enabled and nothing is forced.
module stby_periph_gate (
    input  logic stopped,
    input  logic sub_clk_present,
    input  logic wt_src_sub,
    input  logic clkout_src_sub,
    input  logic tmr8_src_ext,
    output logic tmr16_en,
    output logic wdt_en,
    output logic wt_en,
    output logic tmr8_en,
    output logic clkout_force_low,
    output logic buz_force_low
);

    logic sub_feeds_wt;
    logic sub_feeds_clkout;

    // Decide per peripheral whether its clock survives the stop.
    always_comb begin
        sub_feeds_wt     = wt_src_sub & sub_clk_present;
        sub_feeds_clkout = clkout_src_sub & sub_clk_present;
        tmr16_en         = !stopped;
        wdt_en           = !stopped;
        wt_en            = !stopped || sub_feeds_wt;
        tmr8_en          = !stopped || tmr8_src_ext;
        clkout_force_low = stopped && !sub_feeds_clkout;
        buz_force_low    = stopped;
    end

endmodule

// File: rtl/stby_stop_ctrl.sv
// Top of the stop sequencer. Accepts stop requests from the CPU and
// turns off the main oscillator. It wakes on an unmasked interrupt and
// holds the CPU through the stabilization wait. Runs on an always-on clock.
module stby_stop_ctrl
    import stby_pkg::*;
#(
    parameter int          N_IRQ       = 8,
    parameter int          SYNC_STAGES = 2,
    parameter int unsigned EXP0        = 12,
    parameter int unsigned EXP1        = 14,
    parameter int unsigned EXP2        = 15,
    parameter int unsigned EXP3        = 16,
    parameter int unsigned EXP4        = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_req,
    input  logic             cpu_on_sub,
    input  logic             sub_clk_present,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_mask,
    input  logic [2:0]       stab_sel,
    input  logic             wt_src_sub,
    input  logic             clkout_src_sub,
    input  logic             tmr8_src_ext,
    output logic             main_osc_en,
    output logic             cpu_run,
    output logic             stop_ack,
    output logic             wake_done,
    output logic             port_hold,
    output logic             tmr16_en,
    output logic             wdt_en,
    output logic             wt_en,
    output logic             tmr8_en,
    output logic             clkout_force_low,
    output logic             buz_force_low
);

    stby_state_t state, nxt;
    logic wake_pend, accept, tmr_start, tmr_en, tmr_expired;

    stby_wake_detect #(.N_IRQ(N_IRQ), .SYNC_STAGES(SYNC_STAGES)) u_wake (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_mask(irq_mask),
        .wake_pend(wake_pend)
    );

    stby_stab_timer #(.EXP0(EXP0), .EXP1(EXP1), .EXP2(EXP2), .EXP3(EXP3),
                      .EXP4(EXP4)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .en(tmr_en),
        .sel(stab_sel), .expired(tmr_expired)
    );

    stby_periph_gate u_gate (
        .stopped(state == ST_STOP), .sub_clk_present(sub_clk_present),
        .wt_src_sub(wt_src_sub), .clkout_src_sub(clkout_src_sub),
        .tmr8_src_ext(tmr8_src_ext), .tmr16_en(tmr16_en), .wdt_en(wdt_en),
        .wt_en(wt_en), .tmr8_en(tmr8_en),
        .clkout_force_low(clkout_force_low), .buz_force_low(buz_force_low)
    );

    // Next-state logic and timer control.
    always_comb begin
        accept    = stop_req && !cpu_on_sub;
        nxt       = state;
        tmr_start = 1'b0;
        tmr_en    = (state == ST_WAIT);
        case (state)
            ST_RUN:  if (accept) nxt = wake_pend ? ST_HALT : ST_STOP;
            ST_STOP: if (wake_pend) begin nxt = ST_WAIT; tmr_start = 1'b1; end
            ST_HALT: begin nxt = ST_WAIT; tmr_start = 1'b1; end
            ST_WAIT: if (tmr_expired) nxt = ST_RUN;
            default: nxt = ST_RUN;
        endcase
    end

    // State register and the two event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_RUN;
            stop_ack  <= 1'b0;
            wake_done <= 1'b0;
        end else begin
            state     <= nxt;
            stop_ack  <= (state == ST_RUN) && accept;
            wake_done <= (state == ST_WAIT) && tmr_expired;
        end
    end

    assign cpu_run     = (state == ST_RUN);
    assign main_osc_en = (state != ST_STOP);
    assign port_hold   = (state != ST_RUN);

    assert_ignore_sub_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_run && stop_req && cpu_on_sub) |=> (cpu_run && !stop_ack));

    assert_enter_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_run && stop_req && !cpu_on_sub && !wake_pend) |=> (!main_osc_en && stop_ack));

    assert_ack_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ack |=> !stop_ack);

    assert_demote_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_run && stop_req && !cpu_on_sub && wake_pend) |=> (main_osc_en && !cpu_run && stop_ack));

    assert_stay_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_osc_en && !wake_pend) |=> !main_osc_en);

    assert_wake_osc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_osc_en && wake_pend) |=> (main_osc_en && !cpu_run));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_run) |-> wake_done);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ack |-> port_hold);

    assert_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !main_osc_en |-> (!tmr16_en && !wdt_en && buz_force_low));

endmodule

// File: tb/tb_stby_stop_ctrl.sv
// Directed bench for the stop sequencer with short wait exponents.
module tb_stby_stop_ctrl;

    localparam int N = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic stop_req = 0, cpu_on_sub = 0, sub_clk_present = 0;
    logic [N-1:0] irq_req = '0, irq_mask = '0;
    logic [2:0] stab_sel = 3'd0;
    logic wt_src_sub = 0, clkout_src_sub = 0, tmr8_src_ext = 0;
    logic main_osc_en, cpu_run, stop_ack, wake_done, port_hold;
    logic tmr16_en, wdt_en, wt_en, tmr8_en, clkout_force_low, buz_force_low;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    stby_stop_ctrl #(.N_IRQ(N), .SYNC_STAGES(0), .EXP0(2), .EXP1(4), .EXP2(5),
                     .EXP3(6), .EXP4(7)) dut (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .cpu_on_sub(cpu_on_sub),
        .sub_clk_present(sub_clk_present), .irq_req(irq_req), .irq_mask(irq_mask),
        .stab_sel(stab_sel), .wt_src_sub(wt_src_sub), .clkout_src_sub(clkout_src_sub),
        .tmr8_src_ext(tmr8_src_ext), .main_osc_en(main_osc_en), .cpu_run(cpu_run),
        .stop_ack(stop_ack), .wake_done(wake_done), .port_hold(port_hold),
        .tmr16_en(tmr16_en), .wdt_en(wdt_en), .wt_en(wt_en), .tmr8_en(tmr8_en),
        .clkout_force_low(clkout_force_low), .buz_force_low(buz_force_low)
    );

    function automatic int exp_of(input int code);
        case (code)
            0: return 2;
            1: return 4;
            2: return 5;
            3: return 6;
            default: return 7;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // Enter STOP from run; checks R3 and R9.
    task automatic enter_stop;
        @(negedge clk); stop_req = 1;
        @(negedge clk); stop_req = 0;
        chk("R3 osc off", main_osc_en, 0);
        chk("R3 cpu off", cpu_run, 0);
        chk("R3 ack", stop_ack, 1);
        chk("R9 hold", port_hold, 1);
        @(negedge clk);
        chk("R3 ack single", stop_ack, 0);
    endtask

    // Wake from STOP by line k and measure the wait; checks R5-R8.
    task automatic wake_and_time(input int k, input int code);
        int n;
        stab_sel = 3'(code);
        irq_req[k] = 1;
        @(negedge clk);
        irq_req[k] = 0;
        chk("R5 osc on", main_osc_en, 1);
        chk("R9 hold in wait", port_hold, 1);
        n = 0;
        while (!cpu_run && n < 1000) begin
            @(negedge clk); n++;
        end
        chk($sformatf("R6 R7 wait code %0d", code), n, 1 << exp_of(code));
        chk("R8 done", wake_done, 1);
        @(negedge clk);
        chk("R8 done single", wake_done, 0);
        chk("R9 hold clear", port_hold, 0);
    endtask

    task automatic t_reset;
        chk("R1 cpu", cpu_run, 1);
        chk("R1 osc", main_osc_en, 1);
        chk("R1 ack", stop_ack, 0);
        chk("R1 done", wake_done, 0);
        chk("R1 hold", port_hold, 0);
        chk("R10 run enables", {tmr16_en, wdt_en, wt_en, tmr8_en}, 4'hF);
        chk("R10 run forces", {clkout_force_low, buz_force_low}, 0);
    endtask

    task automatic t_ignore_sub;
        @(negedge clk); cpu_on_sub = 1; stop_req = 1;
        @(negedge clk); stop_req = 0;
        chk("R2 cpu", cpu_run, 1);
        chk("R2 osc", main_osc_en, 1);
        chk("R2 ack", stop_ack, 0);
        @(negedge clk); cpu_on_sub = 0;
        chk("R2 still run", cpu_run, 1);
    endtask

    task automatic t_codes;
        for (int c = 0; c < 8; c++) begin
            enter_stop();
            wake_and_time(c % N, c);
        end
    endtask

    task automatic t_masked;
        enter_stop();
        irq_mask[1] = 1; irq_req[1] = 1;
        repeat (5) @(negedge clk);
        chk("R5 masked ignored", main_osc_en, 0);
        chk("R5 masked cpu", cpu_run, 0);
        irq_req[1] = 0; irq_mask[1] = 0;
        wake_and_time(2, 0);
    endtask

    task automatic t_halt;
        int n;
        stab_sel = 3'd1;
        @(negedge clk); stop_req = 1; irq_req[3] = 1;
        @(negedge clk); stop_req = 0; irq_req[3] = 0;
        chk("R4 osc kept", main_osc_en, 1);
        chk("R4 cpu off", cpu_run, 0);
        chk("R4 ack", stop_ack, 1);
        n = 0;
        while (!cpu_run && n < 1000) begin
            @(negedge clk);
            if (!main_osc_en) chk("R4 osc never off", 0, 1);
            n++;
        end
        chk("R4 R6 wait", n, 1 + (1 << exp_of(1)));
        chk("R8 done halt", wake_done, 1);
    endtask

    task automatic t_periph;
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            sub_clk_present = v[0]; wt_src_sub = v[1];
            clkout_src_sub = v[2]; tmr8_src_ext = v[3];
            enter_stop();
            chk("R10 tmr16", tmr16_en, 0);
            chk("R10 wdt", wdt_en, 0);
            chk("R10 buz", buz_force_low, 1);
            chk("R11 wt", wt_en, int'(v[1] & v[0]));
            chk("R12 clkout", clkout_force_low, int'(!(v[2] & v[0])));
            chk("R13 tmr8", tmr8_en, int'(v[3]));
            wake_and_time(0, 0);
            chk("R10 back", {tmr16_en, wdt_en, wt_en, tmr8_en, buz_force_low}, 5'b11110);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_ignore_sub();
        t_codes();
        t_masked();
        t_halt();
        t_periph();
        finished = 1;
        report();
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            report();
        end
    end

endmodule